// File: doc/BRIEF.md
# Rotated Byte Immediate Codec

This block translates between a 32-bit constant and a compact 12-bit immediate field in which a byte payload is rotated right by an even amount. The field carries a 4-bit rotate count and an 8-bit payload. The constant it stands for is the payload, zero-extended and rotated right by twice the count, so the amounts 0, 2, ..., 30 are possible.

Decoding is purely combinational: a field applied to the decode input gives its constant on the decode output in the same cycle. Encoding is a search. A start strobe captures a 32-bit value. The block then tests one rotate count per clock, starting at zero and counting upward. It stops at the first count that brings the value down into a byte. When it stops, it pulses done and presents the field with a found flag. If no count works, it pulses done with found low and a zero field. Both halves are independent, so a decode may be requested while a search is in flight.

Top module: `rot_imm_codec`

## Requirements
- R1: `decValue` equals the payload `decField[7:0]`, zero-extended to 32 bits and rotated right by 2 x `decField[11:8]` bit positions.
- R2: With rotate count 0, the decoder returns the payload unchanged. A value of 0xFF or less encodes as itself with count 0, and done rises one cycle after the start edge.
- R3: The encoder tests rotate counts 0, 1, ..., 15 in increasing order. It reports the first count r whose left rotation of the value by 2r is at most 0xFF, as field = {r[3:0], rotated[7:0]}. For example, 0x100 encodes as 0xC01.
- R4: If no count fits, `encFound` is 0 and `encField` is 0.
- R5: `encDone` is high in the cycle after the clock edge that tests the accepted count. This is r+1 edges after the start edge on a hit, and 16 edges after it on a miss.
- R6: `encDone` is a single-cycle pulse. `encField` and `encFound` hold their values until the next done.
- R7: A start asserted while a search is running is ignored. It produces no extra done and does not alter the result of the search in progress.
- R8: A start asserted in the cycle in which `encDone` is high is accepted.
- R9: For every value reported as found, decoding `encField` returns the original value.
- R10: After reset, `encDone`, `encFound` and `encField` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| encStart | input | 1 | Start strobe for the encoder, sampled when idle |
| encValue | input | 32 | Value to encode, captured with the start |
| encDone | output | 1 | One-cycle pulse when a search finishes |
| encFound | output | 1 | Set when the last search found an encoding |
| encField | output | 12 | Rotate count (11:8) and payload (7:0) of the last result; zero on a miss |
| decField | input | 12 | Field to decode: rotate count in 11:8, payload in 7:0 |
| decValue | output | 32 | Decoded 32-bit constant |

## Verification
Two encoder events can meet in a single cycle. One case is a fresh start in the cycle where the previous search's done is high. The driver provokes this by launching the next value as soon as it sees done. The scoreboard then expects both results, each with its own start-to-done latency. The other case is a stray start during a 16-cycle miss search. There, the bench expects exactly one result, the one from the first value, and counts every done against the starts it issued. While results arrive, the monitor feeds each found field to the decoder and compares the decoded constant with the original value.

// File: rtl/rot_imm_pkg.sv
package rot_imm_pkg;
  localparam int DATA_W  = 32;
  localparam int PAY_W   = 8;
  localparam int CNT_W   = 4;
  localparam int FIELD_W = CNT_W + PAY_W;
  localparam int ROT_W   = CNT_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;
    logic             test;
    logic             last;
    logic [CNT_W-1:0] cnt;
  } encStrobes_t;

  // rotate via a doubled word so an amount of zero never forms a full-width shift
  function automatic logic [DATA_W-1:0] rotLeft(input logic [DATA_W-1:0] v,
                                                input logic [ROT_W-1:0] n);
    logic [2*DATA_W-1:0] d;
    d = {v, v} << n;
    return d[2*DATA_W-1:DATA_W];
  endfunction

  function automatic logic [DATA_W-1:0] rotRight(input logic [DATA_W-1:0] v,
                                                 input logic [ROT_W-1:0] n);
    logic [2*DATA_W-1:0] d;
    d = {v, v} >> n;
    return d[DATA_W-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] expandField(input logic [FIELD_W-1:0] f);
    return rotRight({{(DATA_W-PAY_W){1'b0}}, f[PAY_W-1:0]}, {f[FIELD_W-1:PAY_W], 1'b0});
  endfunction
endpackage

// File: rtl/rot_imm_decoder.sv
module rot_imm_decoder
  import rot_imm_pkg::*;
(
  input  logic [FIELD_W-1:0] field,
  output logic [DATA_W-1:0]  value
);
  logic [PAY_W-1:0] payload;
  logic [CNT_W-1:0] rotCnt;

  assign payload = field[PAY_W-1:0];
  assign rotCnt  = field[FIELD_W-1:PAY_W];
  assign value   = rotRight({{(DATA_W-PAY_W){1'b0}}, payload}, {rotCnt, 1'b0});

  // R2: a zero count leaves the payload untouched
  always_comb begin
    if (rotCnt == '0) begin
      assert_rot0_passthru_R2: assert (value == {{(DATA_W-PAY_W){1'b0}}, payload});
    end
  end
endmodule

// File: rtl/rot_imm_enc_ctrl.sv
module rot_imm_enc_ctrl
  import rot_imm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startIn,
  input  logic        hit,
  output encStrobes_t strobes,
  output logic        doneOut
);
  logic             busyQ;
  logic [CNT_W-1:0] cntQ;
  logic             doneQ;
  logic             finishing;

  assign finishing = busyQ && (hit || cntQ == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (startIn) begin
          busyQ <= 1'b1;
          cntQ  <= '0;
        end
      end else if (finishing) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end else begin
        cntQ <= cntQ + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.load = !busyQ && startIn;
    strobes.test = busyQ;
    strobes.last = busyQ && (cntQ == CNT_MAX);
    strobes.cnt  = cntQ;
  end

  assign doneOut = doneQ;

  // R6: done lasts exactly one cycle
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R3 / R5: counts advance by one per clock while nothing matches
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !hit && cntQ != CNT_MAX) |=> (busyQ && cntQ == $past(cntQ) + 1'b1));

  // R8: an idle start always begins a search at count zero
  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && startIn) |=> (busyQ && cntQ == '0));

  // R7: a start during a search does not restart it
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && startIn && !finishing) |=> (cntQ != '0));
endmodule

// File: rtl/rot_imm_enc_datapath.sv
module rot_imm_enc_datapath
  import rot_imm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  encStrobes_t        strobes,
  input  logic [DATA_W-1:0]  valueIn,
  output logic               hit,
  output logic [FIELD_W-1:0] fieldOut,
  output logic               foundOut
);
  logic [DATA_W-1:0]  valQ;
  logic [DATA_W-1:0]  rotated;
  logic [FIELD_W-1:0] fieldQ;
  logic               foundQ;

  assign rotated = rotLeft(valQ, {strobes.cnt, 1'b0});
  assign hit     = (rotated[DATA_W-1:PAY_W] == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ   <= '0;
      fieldQ <= '0;
      foundQ <= 1'b0;
    end else begin
      if (strobes.load) begin
        valQ <= valueIn;
      end
      if (strobes.test && (hit || strobes.last)) begin
        foundQ <= hit;
        fieldQ <= hit ? {strobes.cnt, rotated[PAY_W-1:0]} : '0;
      end
    end
  end

  assign fieldOut = fieldQ;
  assign foundOut = foundQ;

  // R4: a miss leaves a zero field
  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    !foundQ |-> (fieldQ == '0));

  // R9: a found field expands back to the captured value
  assert_round_trip_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.test && hit) |=> (expandField(fieldQ) == valQ));
endmodule

// File: rtl/rot_imm_codec.sv
module rot_imm_codec
  import rot_imm_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               encStart,
  input  logic [DATA_W-1:0]  encValue,
  output logic               encDone,
  output logic               encFound,
  output logic [FIELD_W-1:0] encField,
  input  logic [FIELD_W-1:0] decField,
  output logic [DATA_W-1:0]  decValue
);
  encStrobes_t strobes;
  logic        hit;

  rot_imm_enc_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (encStart),
    .hit     (hit),
    .strobes (strobes),
    .doneOut (encDone)
  );

  rot_imm_enc_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .valueIn  (encValue),
    .hit      (hit),
    .fieldOut (encField),
    .foundOut (encFound)
  );

  rot_imm_decoder dec_i (
    .field (decField),
    .value (decValue)
  );
endmodule

// File: tb/rot_imm_codec_tb_top.sv
module rot_imm_codec_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        encStart = 1'b0;
  logic [31:0] encValue = '0;
  logic        encDone;
  logic        encFound;
  logic [11:0] encField;
  logic [11:0] decField = '0;
  logic [31:0] decValue;

  always #(CLK_PERIOD/2) clk = ~clk;

  rot_imm_codec dut_i (
    .clk(clk), .rstN(rstN), .encStart(encStart), .encValue(encValue),
    .encDone(encDone), .encFound(encFound), .encField(encField),
    .decField(decField), .decValue(decValue)
  );

  typedef struct {
    logic [31:0] val;
    logic [11:0] field;
    logic        found;
    int          lat;
    int          startCyc;
  } item_t;

  item_t sbq[$];
  int cyc = 0;
  int nChecks = 0;
  int nFail = 0;
  int issued = 0;
  int doneCnt = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refRor(input logic [31:0] v, input int n);
    logic [31:0] o;
    for (int i = 0; i < 32; i++) o[i] = v[(i + n) % 32];
    return o;
  endfunction

  function automatic void refEncode(input logic [31:0] v, output logic [11:0] f,
                                    output logic fnd, output int lat);
    logic [31:0] t;
    fnd = 0; f = '0; lat = 16;
    for (int r = 0; r < 16; r++) begin
      t = refRor(v, (32 - 2*r) % 32);
      if (!fnd && t <= 32'hFF) begin
        fnd = 1;
        f = {r[3:0], t[7:0]};
        lat = r + 1;
      end
    end
  endfunction

  // called at a negedge; start is sampled at the next posedge
  task automatic issue(input logic [31:0] v);
    item_t it;
    it.val = v;
    refEncode(v, it.field, it.found, it.lat);
    it.startCyc = cyc + 1;
    sbq.push_back(it);
    issued++;
    encStart = 1'b1;
    encValue = v;
    @(negedge clk);
    encStart = 1'b0;
  endtask

  task automatic waitIdle();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic encodeOne(input logic [31:0] v);
    @(negedge clk);
    issue(v);
    waitIdle();
  endtask

  // scoreboard monitor
  bit prevDone = 0;
  logic [11:0] prevField;
  logic prevFound;
  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone) begin
        chk(!encDone, "R6", "done pulse width", {31'd0, encDone}, 32'd0);
        chk(encField == prevField && encFound == prevFound, "R6", "result held",
            {19'd0, encFound, encField}, {19'd0, prevFound, prevField});
      end
      prevDone = encDone;
      if (encDone) begin
        item_t it;
        doneCnt++;
        prevField = encField;
        prevFound = encFound;
        if (sbq.size() == 0) begin
          chk(0, "R7", "unexpected done", {20'd0, encField}, 32'd0);
        end else begin
          it = sbq.pop_front();
          chk(encField == it.field, "R3", "field", {20'd0, encField}, {20'd0, it.field});
          chk(encFound == it.found, "R4", "found", {31'd0, encFound}, {31'd0, it.found});
          chk((cyc - it.startCyc) == it.lat, "R5", "latency", cyc - it.startCyc, it.lat);
          if (it.found) begin
            decField = encField;
            #1;
            chk(decValue == it.val, "R9", "round trip", decValue, it.val);
          end
        end
      end
    end
  end

  task automatic decCheck(input logic [11:0] f, input logic [31:0] exp, input string tag);
    decField = f;
    #1;
    chk(decValue == exp, tag, "decode", decValue, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(encDone == 0 && encFound == 0 && encField == 0, "R10", "reset outputs",
        {19'd0, encDone, encFound, encField[10:0]}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2: direct decoder patterns
    decCheck(12'h0FF, 32'h0000_00FF, "R2");
    decCheck(12'h0AB, 32'h0000_00AB, "R2");
    decCheck(12'h1FF, 32'hC000_003F, "R1");
    decCheck(12'hF01, 32'h0000_0004, "R1");
    decCheck(12'h8A5, 32'h00A5_0000, "R1");
    for (int k = 0; k < 20; k++) begin
      logic [11:0] f;
      f = 12'($urandom);
      decCheck(f, refRor({24'd0, f[7:0]}, 2 * f[11:8]), "R1");
    end

    // corner values: R2 small, R3 first-count order, R4 miss
    encodeOne(32'h0000_0000);  // R2
    encodeOne(32'h0000_00FF);  // R2
    encodeOne(32'h0000_0100);  // R3 -> 0xC01
    encodeOne(32'hFF00_0000);  // R3 -> 0x4FF
    encodeOne(32'hF000_000F);  // R3 -> 0x2FF
    encodeOne(32'h0000_0101);  // R4 miss
    encodeOne(32'h0000_03FC);  // R3 -> 0xFFF
    encodeOne(32'hFFFF_FFFF);  // R4 miss

    // R7: stray start during a miss search
    @(negedge clk);
    issue(32'h0000_0101);
    repeat (3) @(negedge clk);
    encStart = 1'b1;
    encValue = 32'h0000_0055;
    @(negedge clk);
    encStart = 1'b0;
    waitIdle();
    repeat (20) @(negedge clk);
    chk(doneCnt == issued, "R7", "done count after stray start", doneCnt, issued);

    // R8: back-to-back start in the done cycle
    @(negedge clk);
    issue(32'h0000_0040);
    while (!encDone) @(negedge clk);
    issue(32'h0003_FC00);
    while (!encDone) @(negedge clk);
    issue(32'h1234_5678);
    waitIdle();

    // random representable and arbitrary values
    for (int k = 0; k < 30; k++) begin
      logic [7:0] b;
      b = 8'($urandom);
      encodeOne(refRor({24'd0, b}, 2 * ($urandom % 16)));
    end
    for (int k = 0; k < 20; k++) encodeOne($urandom);

    repeat (5) @(negedge clk);
    chk(doneCnt == issued, "R7", "final done count", doneCnt, issued);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule